// File: doc/BRIEF.md
# Output Process Data Watchdog and Slave State Controller

This block keeps the communication state of a fieldbus slave node and supervises the output process data that the master sends to it. The node has four states: INIT, PRE-OPERATIONAL, SAFE-OPERATIONAL and OPERATIONAL. The master asks for a state change by writing a request, together with an optional error-acknowledge bit. The block accepts the request or refuses it. When it refuses, it sets an error flag and reports a 16-bit status code. The local application reports through two inputs whether its initialization succeeded for an upward step, and whether an internal fault has occurred.

While the node is OPERATIONAL, a watchdog counts clock cycles and restarts each time the buffer manager strobes a master write into the output process data area. If the configured number of cycles passes with no such write, the node drops to SAFE-OPERATIONAL, raises the error flag and loads status code 0x001B. A safe-output enable goes high whenever the node is not OPERATIONAL, so that downstream outputs go to their safe condition when communication with the master is lost.

Top module: `pdwd_state_ctrl`

## Requirements
- R1: After reset the state is INIT, the error flag is 0, the status code is 0x0000 and safe_out_en is 1. The state is one-hot in status_reg[3:0] with INIT=1, PREOP=2, SAFEOP=4 and OP=8. The error flag is status_reg[4], and status_reg[7:5] always read 0.
- R2: The watchdog counts only while the state is OP, wd_enable is 1 and wd_timeout is nonzero. With a timeout of T, the state leaves OP at the T-th rising edge after the edge that entered OP or the last edge that sampled pd_wr_strobe high, unless another strobe arrives first. If wd_enable is 0 or wd_timeout is 0, the node stays in OP indefinitely.
- R3: A watchdog expiry sets the state to SAFEOP, sets the error flag and loads status code 0x001B.
- R4: A request is accepted when it names a valid state that is the same as the current state or lower, or the single next step up (INIT to PREOP, PREOP to SAFEOP, SAFEOP to OP). Acceptance takes effect at the sampling edge: the state becomes the requested one, the error flag is cleared and the code becomes 0x0000.
- R5: A legal upward step requested while app_init_ok is 0 is refused. The state is unchanged, the error flag is set and the code is app_fail_code.
- R6: A request with an encoding outside {1,2,4,8} is refused with code 0x0012. An upward request that skips one or more states is refused with code 0x0011. In both cases the state is unchanged and the error flag is set.
- R7: While the error flag is set, a request without req_err_ack has no effect on the state, the flag or the code. A request with req_err_ack is evaluated as if the flag were clear.
- R8: A pulse on app_fault moves the state one level down (OP to SAFEOP, SAFEOP to PREOP, PREOP to INIT, INIT stays INIT). It sets the error flag and loads app_fail_code. A fault takes priority over a request in the same cycle. A watchdog expiry takes priority over a fault.
- R9: safe_out_en is 1 exactly when the state is not OP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_wr_strobe | input | 1 | Master write reached the output process data buffer |
| req_valid | input | 1 | One-cycle pulse: master wrote a state request |
| req_state | input | 4 | Requested state code |
| req_err_ack | input | 1 | Error acknowledge, sent with the request |
| app_init_ok | input | 1 | Application initialization succeeded for an upward step |
| app_fail_code | input | 16 | Code reported on an initialization failure or an internal fault |
| app_fault | input | 1 | Internal application fault pulse |
| wd_enable | input | 1 | Watchdog enable |
| wd_timeout | input | TMR_W | Watchdog time in clock cycles; 0 disables the watchdog |
| status_reg | output | 8 | {3'b0, error flag, one-hot state} |
| status_code | output | 16 | Status code |
| safe_out_en | output | 1 | Drive outputs to their safe condition |

## Verification
Every result is registered once. A request, fault or watchdog expiry sampled at one rising edge shows on status_reg and status_code right after that same edge. The bench drives inputs on falling edges and reads outputs at the next falling edge. For the watchdog, the bench counts edges from the edge that entered OP, or from the edge that sampled the last strobe. It checks the state after every edge of the window: OP for the first T-1 edges and SAFEOP at edge T. This is swept over timeouts 1 to 5 and every strobe position inside the window. Request handling is swept over every current state, every 4-bit request code and both values of the initialization result.

// File: rtl/pdwd_pkg.sv
`timescale 1ns/1ps
// Shared types, codes and helpers for the process data watchdog state controller.
// Assumes the four states are one-hot so that numeric order equals state order.
package pdwd_pkg;

    localparam int ST_W   = 4;
    localparam int CODE_W = 16;

    typedef enum logic [ST_W-1:0] {
        ST_INIT   = 4'h1,
        ST_PREOP  = 4'h2,
        ST_SAFEOP = 4'h4,
        ST_OP     = 4'h8
    } pd_state_e;

    localparam logic [CODE_W-1:0] CODE_NONE     = 16'h0000;
    localparam logic [CODE_W-1:0] CODE_BAD_STEP = 16'h0011;
    localparam logic [CODE_W-1:0] CODE_UNKNOWN  = 16'h0012;
    localparam logic [CODE_W-1:0] CODE_WDOG     = 16'h001B;

    // True when the code names one of the four states.
    function automatic logic state_valid(input logic [ST_W-1:0] s);
        return (s == ST_INIT) || (s == ST_PREOP) || (s == ST_SAFEOP) || (s == ST_OP);
    endfunction

    // One level down; INIT is the floor.
    function automatic pd_state_e state_below(input pd_state_e s);
        case (s)
            ST_OP:     return ST_SAFEOP;
            ST_SAFEOP: return ST_PREOP;
            default:   return ST_INIT;
        endcase
    endfunction

endpackage

// File: rtl/pdwd_timer.sv
`timescale 1ns/1ps
// Watchdog counter. Counts cycles while run is high and limit is nonzero;
// a kick or a stop clears it. expire is combinational and is due in the
// cycle that leads to the limit-th edge since the last clear.
// Assumes the consumer leaves the running condition on expiry.
module pdwd_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             kick,
    input  logic [TMR_W-1:0] limit,
    output logic             expire
);

    logic [TMR_W-1:0] cnt_q;
    logic             active;

    assign active = run && (limit != '0);

    // Cycle counter: cleared by reset, stop or kick, else counts up.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || kick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expiry when the count has reached the last cycle of the window.
    always_comb begin
        expire = active && !kick && (cnt_q >= limit - 1'b1);
    end

endmodule

// File: rtl/pdwd_req_eval.sv
`timescale 1ns/1ps
// Combinational judgement of a master state request against the current state.
// Downward or same-state requests need no initialization; a single upward
// step needs init_ok; everything else is refused with its own code.
module pdwd_req_eval
    import pdwd_pkg::*;
(
    input  pd_state_e         cur,
    input  logic [ST_W-1:0]   req,
    input  logic              init_ok,
    input  logic [CODE_W-1:0] fail_code,
    output logic              accept,
    output logic [CODE_W-1:0] reject_code
);

    logic step_up;

    // Legal single upward steps.
    always_comb begin
        step_up = (cur == ST_INIT   && req == ST_PREOP)  ||
                  (cur == ST_PREOP  && req == ST_SAFEOP) ||
                  (cur == ST_SAFEOP && req == ST_OP);
    end

    // Accept or pick the refusal code.
    always_comb begin
        accept      = 1'b0;
        reject_code = CODE_NONE;
        if (!state_valid(req)) begin
            reject_code = CODE_UNKNOWN;
        end else if (req <= cur) begin
            accept = 1'b1;
        end else if (step_up) begin
            accept      = init_ok;
            reject_code = init_ok ? CODE_NONE : fail_code;
        end else begin
            reject_code = CODE_BAD_STEP;
        end
    end

endmodule

// File: rtl/pdwd_fsm.sv
`timescale 1ns/1ps
// State, error flag and status code registers. Event priority per cycle:
// watchdog expiry, then application fault, then master request.
// Assumes req_valid and fault are single-cycle pulses.
module pdwd_fsm
    import pdwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expire,
    input  logic              fault,
    input  logic [CODE_W-1:0] fail_code,
    input  logic              req_valid,
    input  logic [ST_W-1:0]   req,
    input  logic              req_ack,
    input  logic              accept,
    input  logic [CODE_W-1:0] reject_code,
    output pd_state_e         state,
    output logic              err,
    output logic [CODE_W-1:0] code
);

    pd_state_e         state_d;
    logic              err_d;
    logic [CODE_W-1:0] code_d;

    // Next-state selection by event priority.
    always_comb begin
        state_d = state;
        err_d   = err;
        code_d  = code;
        if (expire) begin
            state_d = ST_SAFEOP;
            err_d   = 1'b1;
            code_d  = CODE_WDOG;
        end else if (fault) begin
            state_d = state_below(state);
            err_d   = 1'b1;
            code_d  = fail_code;
        end else if (req_valid && (!err || req_ack)) begin
            if (accept) begin
                state_d = pd_state_e'(req);
                err_d   = 1'b0;
                code_d  = CODE_NONE;
            end else begin
                err_d   = 1'b1;
                code_d  = reject_code;
            end
        end
    end

    // Status registers with synchronous reset to INIT, no error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_INIT;
            err   <= 1'b0;
            code  <= CODE_NONE;
        end else begin
            state <= state_d;
            err   <= err_d;
            code  <= code_d;
        end
    end

endmodule

// File: rtl/pdwd_state_ctrl.sv
`timescale 1ns/1ps
// Top: slave state controller with output process data watchdog.
// The watchdog runs only in OP; outputs are held safe below OP.
// Assumes all inputs are synchronous to clk.
module pdwd_state_ctrl
    import pdwd_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pd_wr_strobe,
    input  logic               req_valid,
    input  logic [3:0]         req_state,
    input  logic               req_err_ack,
    input  logic               app_init_ok,
    input  logic [15:0]        app_fail_code,
    input  logic               app_fault,
    input  logic               wd_enable,
    input  logic [TMR_W-1:0]   wd_timeout,
    output logic [7:0]         status_reg,
    output logic [15:0]        status_code,
    output logic               safe_out_en
);

    localparam int PAD_W = 8 - ST_W - 1;

    pd_state_e         state;
    logic              err;
    logic              wd_expire;
    logic              req_accept;
    logic [CODE_W-1:0] req_reject_code;

    pdwd_timer #(.TMR_W(TMR_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    ((state == ST_OP) && wd_enable),
        .kick   (pd_wr_strobe),
        .limit  (wd_timeout),
        .expire (wd_expire)
    );

    pdwd_req_eval u_eval (
        .cur         (state),
        .req         (req_state),
        .init_ok     (app_init_ok),
        .fail_code   (app_fail_code),
        .accept      (req_accept),
        .reject_code (req_reject_code)
    );

    pdwd_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .expire      (wd_expire),
        .fault       (app_fault),
        .fail_code   (app_fail_code),
        .req_valid   (req_valid),
        .req         (req_state),
        .req_ack     (req_err_ack),
        .accept      (req_accept),
        .reject_code (req_reject_code),
        .state       (state),
        .err         (err),
        .code        (status_code)
    );

    // Pack the status word and derive the safe-output enable.
    always_comb begin
        status_reg  = {{PAD_W{1'b0}}, err, state};
        safe_out_en = (state != ST_OP);
    end

endmodule

// File: rtl/pdwd_chk.sv
`timescale 1ns/1ps
// Assertion checker for pdwd_state_ctrl, bound to every instance of the top.
module pdwd_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pd_wr_strobe,
    input logic        req_valid,
    input logic        req_err_ack,
    input logic        app_fault,
    input logic [7:0]  status_reg,
    input logic [15:0] status_code,
    input logic        safe_out_en
);

    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(status_reg[3:0]) == 1 && status_reg[7:5] == 3'b000); // R1

    AST_STROBE_KEEPS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pd_wr_strobe) && $past(status_reg[3]) && !$past(app_fault) && !$past(req_valid))
        |-> status_reg[3]); // R2

    AST_WDOG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(status_reg[3]) && !$past(app_fault) && !$past(req_valid))
        |-> (status_code == 16'h001B && status_reg[4] && status_reg[2])); // R3

    AST_INIT_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status_reg[0]) && !status_reg[0]) |-> status_reg[1]); // R4

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status_reg[4]) && !($past(req_valid) && $past(req_err_ack)))
        |-> status_reg[4]); // R7

    AST_SAFE_BELOW_OP: assert property (@(posedge clk) disable iff (!rst_n)
        safe_out_en != status_reg[3]); // R9

endmodule

bind pdwd_state_ctrl pdwd_chk u_chk (.*);

// File: tb/pdwd_state_ctrl_tb.sv
`timescale 1ns/1ps
module pdwd_state_ctrl_tb;

    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pd_wr_strobe = 1'b0;
    logic          req_valid = 1'b0;
    logic [3:0]    req_state = 4'h0;
    logic          req_err_ack = 1'b0;
    logic          app_init_ok = 1'b1;
    logic [15:0]   app_fail_code = 16'h0123;
    logic          app_fault = 1'b0;
    logic          wd_enable = 1'b0;
    logic [TW-1:0] wd_timeout = '0;
    logic [7:0]    status_reg;
    logic [15:0]   status_code;
    logic          safe_out_en;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pdwd_state_ctrl #(.TMR_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .pd_wr_strobe(pd_wr_strobe),
        .req_valid(req_valid), .req_state(req_state), .req_err_ack(req_err_ack),
        .app_init_ok(app_init_ok), .app_fail_code(app_fail_code), .app_fault(app_fault),
        .wd_enable(wd_enable), .wd_timeout(wd_timeout),
        .status_reg(status_reg), .status_code(status_code), .safe_out_en(safe_out_en)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Full status check; safe_out_en follows from the expected state (R9).
    task automatic check_all(input string tag, input logic [3:0] st, input logic er,
                             input logic [15:0] cd);
        check({tag, " status"}, {24'd0, status_reg}, {24'd0, 3'b000, er, st});
        check({tag, " code"}, {16'd0, status_code}, {16'd0, cd});
        check({tag, " R9 safe_out_en"}, {31'd0, safe_out_en}, {31'd0, st != 4'h8});
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_valid = 1'b0; app_fault = 1'b0; pd_wr_strobe = 1'b0;
        req_err_ack = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic request(input logic [3:0] st, input logic ack, input logic ok);
        req_valid = 1'b1; req_state = st; req_err_ack = ack; app_init_ok = ok;
        @(negedge clk);
        req_valid = 1'b0; req_err_ack = 1'b0; app_init_ok = 1'b1;
    endtask

    task automatic climb(input logic [3:0] target);
        do_reset();
        for (int s = 2; s <= 8; s = s * 2)
            if (4'(s) <= target) request(4'(s), 1'b0, 1'b1);
    endtask

    // Expected result of a request from a clean state: {state, err, code}.
    function automatic logic [20:0] model(input logic [3:0] cur, input logic [3:0] r,
                                          input logic ok, input logic [15:0] fc);
        logic valid, up;
        valid = (r == 4'h1) || (r == 4'h2) || (r == 4'h4) || (r == 4'h8);
        up    = valid && (r == {cur[2:0], 1'b0}) && cur != 4'h8;
        if (!valid)        return {cur, 1'b1, 16'h0012};
        else if (r <= cur) return {r, 1'b0, 16'h0000};
        else if (up)       return ok ? {r, 1'b0, 16'h0000} : {cur, 1'b1, fc};
        else               return {cur, 1'b1, 16'h0011};
    endfunction

    initial begin
        #(20 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [20:0] e;
        string tg;
        @(negedge clk);
        do_reset();
        check_all("R1 reset", 4'h1, 1'b0, 16'h0000);

        // Request sweep: every state, every code, both init results (R4 R5 R6).
        for (int c = 1; c <= 8; c = c * 2) begin
            for (int r = 0; r < 16; r++) begin
                for (int ok = 0; ok < 2; ok++) begin
                    climb(4'(c));
                    request(4'(r), 1'b0, 1'(ok));
                    e = model(4'(c), 4'(r), 1'(ok), app_fail_code);
                    if (!e[16])                    tg = "R4 accept";
                    else if (e[15:0] == app_fail_code) tg = "R5 init fail";
                    else                           tg = "R6 refuse";
                    check_all(tg, e[20:17], e[16], e[15:0]);
                end
            end
        end

        // Watchdog with no strobe: drop at T-th edge after entering OP (R2 R3).
        for (int t = 1; t <= 5; t++) begin
            wd_enable = 1'b1; wd_timeout = TW'(t);
            climb(4'h4);
            request(4'h8, 1'b0, 1'b1);
            check("R2 entered OP", {28'd0, status_reg[3:0]}, 32'h8);
            for (int k = 1; k <= t; k++) begin
                @(negedge clk);
                if (k < t) check("R2 still OP", {28'd0, status_reg[3:0]}, 32'h8);
            end
            check_all("R3 expiry", 4'h4, 1'b1, 16'h001B);
        end

        // Watchdog restart by strobe at every position inside the window (R2).
        for (int t = 2; t <= 5; t++) begin
            for (int m = 1; m < t; m++) begin
                wd_enable = 1'b1; wd_timeout = TW'(t);
                climb(4'h4);
                request(4'h8, 1'b0, 1'b1);
                repeat (m - 1) @(negedge clk);
                pd_wr_strobe = 1'b1;
                @(negedge clk);
                pd_wr_strobe = 1'b0;
                check("R2 OP at strobe", {28'd0, status_reg[3:0]}, 32'h8);
                for (int k = 1; k <= t; k++) begin
                    @(negedge clk);
                    check("R2 window after strobe", {28'd0, status_reg[3:0]},
                          (k < t) ? 32'h8 : 32'h4);
                end
            end
        end

        // Disabled watchdog: by enable and by zero timeout (R2).
        wd_enable = 1'b0; wd_timeout = TW'(2);
        climb(4'h8);
        repeat (12) @(negedge clk);
        check_all("R2 disabled", 4'h8, 1'b0, 16'h0000);
        wd_enable = 1'b1; wd_timeout = '0;
        climb(4'h8);
        repeat (12) @(negedge clk);
        check_all("R2 zero timeout", 4'h8, 1'b0, 16'h0000);

        // Sticky error and acknowledge (R7).
        wd_enable = 1'b1; wd_timeout = TW'(3);
        climb(4'h8);
        repeat (3) @(negedge clk);
        check_all("R3 expiry t3", 4'h4, 1'b1, 16'h001B);
        request(4'h8, 1'b0, 1'b1);
        check_all("R7 no ack ignored", 4'h4, 1'b1, 16'h001B);
        request(4'h1, 1'b0, 1'b1);
        check_all("R7 no ack ignored down", 4'h4, 1'b1, 16'h001B);
        wd_enable = 1'b0;
        request(4'h8, 1'b1, 1'b1);
        check_all("R7 ack accepted", 4'h8, 1'b0, 16'h0000);
        request(4'h3, 1'b0, 1'b1);
        request(4'h4, 1'b1, 1'b1);
        check_all("R7 ack after refusal", 4'h4, 1'b0, 16'h0000);

        // Fault steps down one level, INIT is the floor (R8).
        climb(4'h8);
        app_fail_code = 16'h0A5C;
        for (int k = 0; k < 4; k++) begin
            app_fault = 1'b1;
            @(negedge clk);
            app_fault = 1'b0;
            check_all("R8 fault step", (k < 3) ? 4'(8 >> (k + 1)) : 4'h1, 1'b1, 16'h0A5C);
        end

        // Fault beats request in the same cycle (R8).
        climb(4'h4);
        app_fault = 1'b1;
        request(4'h8, 1'b0, 1'b1);
        app_fault = 1'b0;
        check_all("R8 fault over request", 4'h2, 1'b1, 16'h0A5C);

        // Expiry beats fault in the same cycle (R8).
        wd_enable = 1'b1; wd_timeout = TW'(2);
        climb(4'h4);
        request(4'h8, 1'b0, 1'b1);
        @(negedge clk);
        app_fault = 1'b1;
        @(negedge clk);
        app_fault = 1'b0;
        check_all("R8 expiry over fault", 4'h4, 1'b1, 16'h001B);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule